// File: doc/BRIEF.md
# Two-Group ADC Scan Sequencer

This block sequences a four-input scanning analog-to-digital converter so that eight channels are refreshed once per system tick. A tick launches a scan of the first group (channels 0 to 3). When the converter reports that group finished, the block stores the four results and immediately launches the second group (channels 4 to 7). When that group finishes, its four results are stored and the block stays quiet until the next tick. The converter itself is outside the block. It only sees a start strobe, a group select and the scan-mode and completion-signalling enables.

The converter hands back each result left-justified in a 16-bit word. The block keeps only the upper 10 bits, which is the word shifted right by six, in an eight-entry register file. A read port indexes that file combinationally at any time. Reading never disturbs the sequencing. With a conversion group taking around a thousand cycles, both groups finish well within one tick period.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, all outputs are 0 and every stored channel reads back 0.
- R2: A tick sampled while the sequencer is idle makes `conv_start_o` high in the following cycle, with `grp_sel_o` = 0 (channels 0 to 3) and both `scan_en_o` and `irq_en_o` = 1.
- R3: A `conv_done_i` sampled while `scan_en_o` = 1 and `grp_sel_o` = 0 stores lane k of `conv_res_i` (bits 16k+15 down to 16k) as channel k, readable from the next cycle. In that same next cycle `scan_en_o` and `irq_en_o` are 0 (the control word is cleared).
- R4: Two cycles after that first-group completion, `conv_start_o` pulses with `grp_sel_o` = 1 (channels 4 to 7) and both enables at 1.
- R5: A `conv_done_i` sampled while `scan_en_o` = 1 and `grp_sel_o` = 1 stores lane k as channel 4+k. It clears both enables and returns `grp_sel_o` to 0. No further start occurs until a new tick.
- R6: The stored value is bits 15 down to 6 of the 16-bit lane. Bits 5 down to 0 have no effect.
- R7: `rd_val_o` shows the last stored value of channel `rd_ch_i` in the same cycle. Reading never causes a start and never changes a stored value.
- R8: A `conv_done_i` that arrives while the sequencer is idle is ignored. No start occurs and no stored value changes.
- R9: A tick that arrives while a scan is in progress is dropped. It is not queued to run after the scan ends.
- R10: `conv_start_o` is a single-cycle pulse and is only ever high together with `scan_en_o` and `irq_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | System tick pulse; launches a two-group scan |
| conv_done_i | input | 1 | Converter reports the current group finished |
| conv_res_i | input | 64 | Four 16-bit left-justified lane results, lane k at bits 16k+15:16k |
| rd_ch_i | input | 3 | Channel index for the read port |
| rd_val_o | output | 10 | Stored value of the indexed channel |
| conv_start_o | output | 1 | One-cycle start strobe to the converter |
| grp_sel_o | output | 1 | Group in flight: 0 = channels 0-3, 1 = channels 4-7 |
| scan_en_o | output | 1 | Scan-mode enable of the converter control word |
| irq_en_o | output | 1 | Completion-signalling enable of the converter control word |

## Verification
The results of a tick are due at fixed cycles. The first start is due one cycle after the tick edge. Stored results and the cleared enables are due one cycle after the completion edge. The chained second-group start is due two cycles after that edge. The converter stub drives `conv_done_i` at a falling edge and pushes the expected channel values into a scoreboard queue at the falling edge after the capturing rising edge. It checks the cleared enables there and the chained start at the falling edge after that. A monitor pops the queue and compares each value through the read port before the next rising edge. Dropped ticks and ignored completions are judged by a bench-owned count of start pulses and by read-back of every channel.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Sequencer state; one bit tracks the group in flight
    typedef struct packed {
        logic active;    // a two-group scan is under way
        logic grp;       // 0: lower channel group, 1: upper channel group
        logic relaunch;  // control word was cleared, upper group starts next
        logic start;     // start strobe towards the converter
        logic scan_en;   // scan mode bit of the control word
        logic irq_en;    // completion signalling bit of the control word
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '0;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic done_i,
    output logic start_o,
    output logic grp_o,
    output logic scan_en_o,
    output logic irq_en_o,
    output logic active_o,
    output logic wr_en_o,
    output logic wr_grp_o
);

    seq_state_t state_d, state_q;
    logic       accept_done;

    always_comb begin
        state_d       = state_q;
        state_d.start = 1'b0;
        accept_done   = done_i && state_q.scan_en;

        if (state_q.relaunch) begin
            // second group follows the cleared control word by one cycle
            state_d.relaunch = 1'b0;
            state_d.start    = 1'b1;
            state_d.scan_en  = 1'b1;
            state_d.irq_en   = 1'b1;
        end else if (accept_done) begin
            state_d.scan_en = 1'b0;
            state_d.irq_en  = 1'b0;
            if (!state_q.grp) begin
                state_d.grp      = 1'b1;
                state_d.relaunch = 1'b1;
            end else begin
                state_d.grp    = 1'b0;
                state_d.active = 1'b0;
            end
        end else if (tick_i && !state_q.active) begin
            state_d.active  = 1'b1;
            state_d.grp     = 1'b0;
            state_d.start   = 1'b1;
            state_d.scan_en = 1'b1;
            state_d.irq_en  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_o   = state_q.start;
    assign grp_o     = state_q.grp;
    assign scan_en_o = state_q.scan_en;
    assign irq_en_o  = state_q.irq_en;
    assign active_o  = state_q.active;
    assign wr_en_o   = accept_done && !state_q.relaunch;
    assign wr_grp_o  = state_q.grp;

endmodule

// File: rtl/adc_lane_trim.sv
module adc_lane_trim #(
    parameter int RAW_W = 16,
    parameter int RES_W = 10,
    localparam int DROP_W = RAW_W - RES_W
) (
    input  logic [RAW_W-1:0] raw_i,
    output logic [RES_W-1:0] res_o
);

    logic unused_low;

    // left-justified converter word: keep the top RES_W bits
    assign res_o      = raw_i[RAW_W-1 -: RES_W];
    assign unused_low = ^raw_i[DROP_W-1:0];

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int LANES = 4,
    parameter int RES_W = 10,
    localparam int NUM_CH = 2 * LANES,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic                   wr_grp_i,
    input  logic [LANES*RES_W-1:0] wr_data_i,
    input  logic [CH_W-1:0]        rd_ch_i,
    output logic [RES_W-1:0]       rd_val_o
);

    logic [RES_W-1:0] bank_d [NUM_CH];
    logic [RES_W-1:0] bank_q [NUM_CH];

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i) begin
            for (int l = 0; l < LANES; l++) begin
                bank_d[{wr_grp_i, LANE_W'(l)}] = wr_data_i[l*RES_W +: RES_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                bank_q[c] <= '0;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_val_o = bank_q[rd_ch_i];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int LANES = 4,
    parameter int RAW_W = 16,
    parameter int RES_W = 10,
    localparam int NUM_CH = 2 * LANES,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   conv_done_i,
    input  logic [LANES*RAW_W-1:0] conv_res_i,
    input  logic [CH_W-1:0]        rd_ch_i,
    output logic [RES_W-1:0]       rd_val_o,
    output logic                   conv_start_o,
    output logic                   grp_sel_o,
    output logic                   scan_en_o,
    output logic                   irq_en_o
);

    logic                   wr_en;
    logic                   wr_grp;
    logic                   seq_active;
    logic [LANES*RES_W-1:0] trimmed;

    adc_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .done_i    (conv_done_i),
        .start_o   (conv_start_o),
        .grp_o     (grp_sel_o),
        .scan_en_o (scan_en_o),
        .irq_en_o  (irq_en_o),
        .active_o  (seq_active),
        .wr_en_o   (wr_en),
        .wr_grp_o  (wr_grp)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_trim
        adc_lane_trim #(
            .RAW_W (RAW_W),
            .RES_W (RES_W)
        ) u_trim (
            .raw_i (conv_res_i[g*RAW_W +: RAW_W]),
            .res_o (trimmed[g*RES_W +: RES_W])
        );
    end

    adc_result_bank #(
        .LANES (LANES),
        .RES_W (RES_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_grp_i  (wr_grp),
        .wr_data_i (trimmed),
        .rd_ch_i   (rd_ch_i),
        .rd_val_o  (rd_val_o)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic conv_done_i,
    input logic conv_start_o,
    input logic grp_sel_o,
    input logic scan_en_o,
    input logic irq_en_o,
    input logic active_i
);

    AST_TICK_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !active_i |=> conv_start_o && !grp_sel_o && scan_en_o); // R2

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i && scan_en_o |=> !scan_en_o && !irq_en_o); // R3

    AST_CHAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i && scan_en_o && !grp_sel_o |=> ##1 (conv_start_o && grp_sel_o)); // R4

    AST_SCAN_END: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i && scan_en_o && grp_sel_o |=> !active_i && !grp_sel_o); // R5

    AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i && !active_i && !tick_i |=> !conv_start_o && !scan_en_o); // R8

    AST_TICK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && active_i && scan_en_o |=> !conv_start_o); // R9

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o); // R10

    AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> scan_en_o && irq_en_o); // R10

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .grp_sel_o    (grp_sel_o),
    .scan_en_o    (scan_en_o),
    .irq_en_o     (irq_en_o),
    .active_i     (seq_active)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/10ps
module adc_scan_seq_tb;

    localparam int LAT = 20;

    typedef struct packed {
        logic [2:0] ch;
        logic [9:0] val;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        done = 1'b0;
    logic [63:0] res = '0;
    logic [2:0]  rd_ch = '0;
    logic [9:0]  rd_val;
    logic        start, grp, scan_en, irq_en;

    int   total = 0;
    int   fails = 0;
    int   start_cnt = 0;
    int   grp_done_cnt = 0;
    int   seq = 0;
    bit   chain = 1'b0;
    bit   finished = 1'b0;
    logic [9:0] model [8];
    exp_t exp_q [$];

    always #2 clk = ~clk;

    adc_scan_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .conv_done_i  (done),
        .conv_res_i   (res),
        .rd_ch_i      (rd_ch),
        .rd_val_o     (rd_val),
        .conv_start_o (start),
        .grp_sel_o    (grp),
        .scan_en_o    (scan_en),
        .irq_en_o     (irq_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_raw(input int s, input logic g, input int l);
        case (s % 4)
            1:       mk_raw = 16'hFFFF;
            2:       mk_raw = 16'h003F;
            default: mk_raw = {10'(s * 37 + l * 101 + (g ? 211 : 0)), 6'(l * 9 + 5)};
        endcase
    endfunction

    // count start strobes independently of the design
    initial forever begin
        @(negedge clk);
        if (start) start_cnt++;
    end

    // converter stub with fixed latency; pushes expected values
    initial forever begin
        @(negedge clk);
        if (chain) begin
            check(start && grp && scan_en && irq_en, "R4", "chained upper start",
                  int'({start, grp, scan_en, irq_en}), 15);
            chain = 1'b0;
        end
        if (start) begin
            logic g;
            logic [15:0] raw [4];
            g = grp;
            check(scan_en && irq_en, "R10", "enables with start",
                  int'({scan_en, irq_en}), 3);
            @(negedge clk);
            check(!start, "R10", "start is one cycle", int'(start), 0);
            repeat (LAT - 2) @(negedge clk);
            for (int l = 0; l < 4; l++) begin
                raw[l] = mk_raw(seq, g, l);
                res[l*16 +: 16] = raw[l];
            end
            done = 1'b1;
            @(negedge clk);
            done = 1'b0;
            res  = 64'hA5A5_5A5A_C3C3_3C3C;
            check(!scan_en && !irq_en, g ? "R5" : "R3", "control word cleared",
                  int'({scan_en, irq_en}), 0);
            if (g) begin
                check(!grp && !start, "R5", "back to idle group, no start",
                      int'({grp, start}), 0);
            end else begin
                chain = 1'b1;
            end
            for (int l = 0; l < 4; l++) begin
                exp_q.push_back('{ch: {g, 2'(l)}, val: raw[l][15:6]});
            end
            seq++;
            grp_done_cnt++;
        end
    end

    // scoreboard monitor
    initial forever begin
        exp_t it;
        wait (exp_q.size() > 0);
        it = exp_q.pop_front();
        rd_ch = it.ch;
        #0.1;
        check(rd_val == it.val, (it.ch < 4) ? "R3" : "R5", "stored value (R6 trim)",
              int'(rd_val), int'(it.val));
        model[it.ch] = it.val;
    end

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wait_groups(input int n);
        while (grp_done_cnt < n) @(negedge clk);
        @(negedge clk);
        wait (exp_q.size() == 0);
        #0.5;
    endtask

    task automatic read_all(input string req, input string what);
        for (int c = 0; c < 8; c++) begin
            rd_ch = 3'(c);
            #0.1;
            check(rd_val == model[c], req, what, int'(rd_val), int'(model[c]));
        end
    endtask

    initial begin
        int snap;
        for (int c = 0; c < 8; c++) model[c] = '0;
        repeat (3) @(negedge clk);
        check({start, grp, scan_en, irq_en} == 4'b0, "R1", "outputs in reset",
              int'({start, grp, scan_en, irq_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({start, grp, scan_en, irq_en} == 4'b0, "R1", "outputs after reset",
              int'({start, grp, scan_en, irq_en}), 0);
        read_all("R1", "channel zero after reset");

        // R8: completion while idle
        @(negedge clk);
        res  = '1;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        repeat (2) @(negedge clk);
        check(start_cnt == 0 && !scan_en, "R8", "idle done starts nothing",
              start_cnt, 0);
        read_all("R8", "idle done stores nothing");

        // first scan
        do_tick();
        #0.1;
        check(start && !grp && scan_en && irq_en, "R2", "start after tick",
              int'({start, grp, scan_en, irq_en}), 11);
        wait_groups(2);
        check(start_cnt == 2, "R4", "two starts per tick", start_cnt, 2);
        repeat (60) @(negedge clk);
        check(start_cnt == 2 && !scan_en, "R5", "quiet until next tick", start_cnt, 2);

        // R7: reads are side-effect free
        read_all("R7", "read back");
        read_all("R7", "repeated read back");
        check(start_cnt == 2, "R7", "reads start nothing", start_cnt, 2);

        // second scan with a dropped tick
        do_tick();
        repeat (8) @(negedge clk);
        rd_ch = 3'd5;
        #0.1;
        check(rd_val == model[5], "R7", "old value mid-scan", int'(rd_val), int'(model[5]));
        do_tick();
        wait_groups(4);
        repeat (60) @(negedge clk);
        check(start_cnt == 4, "R9", "busy tick dropped, not queued", start_cnt, 4);

        // third scan
        snap = start_cnt;
        do_tick();
        wait_groups(6);
        repeat (20) @(negedge clk);
        check(start_cnt == snap + 2, "R2", "third scan starts", start_cnt, snap + 2);
        read_all("R6", "final contents");

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule